// File: doc/BRIEF.md
# Security-Partitioned Interrupt Register Bank

This block is the register file of a small interrupt controller. For each external interrupt it holds an enable bit, a pending bit, an active bit and an 8-bit priority. It also holds one target bit per interrupt that assigns the interrupt to either the secure or the non-secure world. Software reaches all of this through a single 32-bit read/write port. Every access on that port carries a secure flag.

A non-secure requester sees a filtered view of the bank. Fields that belong to secure-targeted interrupts read as zero, and writes to them are dropped. The target bits themselves can be read and changed only by secure accesses. When the block is built without the security extension, every interrupt counts as non-secure and the target window does not exist. The active bits are not software-writable. They are moved only by side-band set and clear strobes. All state is visible on per-interrupt status outputs.

Top module: `sirq_bank`

## Requirements
- R1: A read of byte offset 0x000 returns NUM_IRQ/32 - 1, with no error. Writes to it are ignored and raise no error.
- R2: In the set-enable words at 0x100+4n and the clear-enable words at 0x180+4n, bit i stands for interrupt 32n+i. Writing 1 to a bit sets the enable (set-enable words) or clears it (clear-enable words). Writing 0 has no effect. Reads of either word return the enable bitmap.
- R3: The set-pending words at 0x200+4n and the clear-pending words at 0x280+4n behave like R2, acting on the pending bits.
- R4: The words at 0x300+4n read the active bitmap. Writes to them are ignored without error. An active bit is set by its side-band set strobe and cleared by its clear strobe. If both strobes are high in the same cycle, the set wins.
- R5: In the priority word at 0x400+4n, byte lane i (bits 8i+7..8i) holds the full 8-bit priority of interrupt 4n+i.
- R6: In the target word at 0x380+4n, bit i is the target of interrupt 32n+i. A value of 1 means non-secure. Secure accesses read and write these bits.
- R7: A non-secure read of the target window returns zero. A non-secure write to it changes nothing.
- R8: In a non-secure access to the enable, pending or active words, a bit whose interrupt targets secure reads as 0, and a 1 written to that bit has no effect.
- R9: In a non-secure access to a priority word, the byte lane of a secure-targeted interrupt reads as zero, and a write to that lane is ignored. Other lanes of the same word are still written.
- R10: Reset (synchronous, active high) clears all enable, pending, active and priority state. With the extension present (SEC_EXT=1), reset also clears every target bit, so every interrupt targets secure.
- R11: With SEC_EXT=0, every target bit is constantly 1. Offsets in the target window are then undefined, and every access sees all interrupts.
- R12: Any other offset is undefined. This includes a word whose interrupt range lies at or beyond NUM_IRQ. A read of an undefined offset returns zero with the error flag set. A write to one changes nothing and also sets the error flag.
- R13: A write to a target word governs the very next access that filters by target.
- R14: Every access produces rsp_valid, rsp_rdata and rsp_err in the cycle after it is presented. For writes, rsp_rdata is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access presented this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_secure | input | 1 | Requester security attribute, 1 = secure |
| acc_addr | input | 12 | Byte offset, word aligned |
| acc_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's access |
| rsp_rdata | output | 32 | Read data (zero for writes and errors) |
| rsp_err | output | 1 | Undefined offset was accessed |
| act_set | input | NUM_IRQ | Side-band active set strobes |
| act_clr | input | NUM_IRQ | Side-band active clear strobes |
| irq_enabled | output | NUM_IRQ | Enable bits |
| irq_pending | output | NUM_IRQ | Pending bits |
| irq_active | output | NUM_IRQ | Active bits |
| irq_target_ns | output | NUM_IRQ | Target bits, 1 = non-secure |
| irq_prio | output | 8*NUM_IRQ | Priorities, interrupt k in bits 8k+7..8k |

## Verification
The stimulus concentrates on priority words and bitmaps that mix secure and non-secure interrupts. A design that filtered by word instead of by bit or lane would leak secure bits to non-secure reads, or drop valid non-secure writes. The target window is attacked with non-secure reads and writes: a missing security check shows up as a changed target value or as non-zero data. Words just past the implemented interrupt count, and the last valid priority word, separate a wrong range check from a correct one. A second instance built without the extension confirms that the window then returns an error and that non-secure requesters see everything. Same-cycle set and clear on the active strobes exposes a reversed priority between them.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

    typedef enum logic [3:0] {
        RG_TYPE,
        RG_SETEN,
        RG_CLREN,
        RG_SETPEND,
        RG_CLRPEND,
        RG_ACTIVE,
        RG_TARGET,
        RG_PRIO,
        RG_BAD
    } region_e;

    typedef struct packed {
        region_e    rg;
        logic [5:0] idx;
    } dec_t;

    // Bitmap groups occupy 128-byte windows selected by addr[11:7].
    localparam logic [4:0] GRP_SETEN   = 5'd2;
    localparam logic [4:0] GRP_CLREN   = 5'd3;
    localparam logic [4:0] GRP_SETPEND = 5'd4;
    localparam logic [4:0] GRP_CLRPEND = 5'd5;
    localparam logic [4:0] GRP_ACTIVE  = 5'd6;
    localparam logic [4:0] GRP_TARGET  = 5'd7;
    localparam logic [3:0] PRIO_PAGE   = 4'h4;

    function automatic dec_t decode_addr(input logic [11:0] a, input int n_bm,
                                         input int n_pr, input bit sec_ext);
        dec_t d;
        d.rg  = RG_BAD;
        d.idx = '0;
        if (a[11:2] == '0) begin
            d.rg = RG_TYPE;
        end else if (a[11:7] >= GRP_SETEN && a[11:7] <= GRP_TARGET) begin
            d.idx = {1'b0, a[6:2]};
            if (int'(a[6:2]) < n_bm) begin
                case (a[11:7])
                    GRP_SETEN:   d.rg = RG_SETEN;
                    GRP_CLREN:   d.rg = RG_CLREN;
                    GRP_SETPEND: d.rg = RG_SETPEND;
                    GRP_CLRPEND: d.rg = RG_CLRPEND;
                    GRP_ACTIVE:  d.rg = RG_ACTIVE;
                    default:     d.rg = sec_ext ? RG_TARGET : RG_BAD;
                endcase
            end
        end else if (a[11:8] == PRIO_PAGE) begin
            d.idx = a[7:2];
            if (int'(a[7:2]) < n_pr) d.rg = RG_PRIO;
        end
        return d;
    endfunction

endpackage

// File: rtl/sirq_irq_cell.sv
module sirq_irq_cell
    import sirq_pkg::*;
#(
    parameter int IRQ_ID  = 0,
    parameter bit SEC_EXT = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_stb,
    input  dec_t        dec,
    input  logic [31:0] wdata,
    input  logic        secure,
    input  logic        act_set,
    input  logic        act_clr,
    output logic        en_o,
    output logic        pend_o,
    output logic        act_o,
    output logic        tgt_ns_o,
    output logic [7:0]  prio_o
);
    localparam logic [5:0] BM_WORD = 6'(IRQ_ID / 32);
    localparam int         BM_BIT  = IRQ_ID % 32;
    localparam logic [5:0] PR_WORD = 6'(IRQ_ID / 4);
    localparam int         PR_LANE = IRQ_ID % 4;

    logic allow;
    logic bm_hit;
    logic pr_hit;

    assign allow  = secure | tgt_ns_o;
    assign bm_hit = wr_stb && (dec.idx == BM_WORD) && wdata[BM_BIT] && allow;
    assign pr_hit = wr_stb && (dec.rg == RG_PRIO) && (dec.idx == PR_WORD) && allow;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_o   <= 1'b0;
            pend_o <= 1'b0;
            act_o  <= 1'b0;
            prio_o <= '0;
        end else begin
            if (bm_hit) begin
                case (dec.rg)
                    RG_SETEN:   en_o   <= 1'b1;
                    RG_CLREN:   en_o   <= 1'b0;
                    RG_SETPEND: pend_o <= 1'b1;
                    RG_CLRPEND: pend_o <= 1'b0;
                    default: ;
                endcase
            end
            if (pr_hit) prio_o <= wdata[8*PR_LANE +: 8];
            if (act_set)      act_o <= 1'b1;
            else if (act_clr) act_o <= 1'b0;
        end
    end

    generate
        if (SEC_EXT) begin : g_tgt_reg
            logic tgt_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    tgt_q <= 1'b0;
                end else if (wr_stb && secure && dec.rg == RG_TARGET
                             && dec.idx == BM_WORD) begin
                    tgt_q <= wdata[BM_BIT];
                end
            end
            assign tgt_ns_o = tgt_q;
        end else begin : g_tgt_const
            assign tgt_ns_o = 1'b1;
        end
    endgenerate

endmodule

// File: rtl/sirq_rd_mux.sv
module sirq_rd_mux
    import sirq_pkg::*;
#(
    parameter int NUM_IRQ = 64
) (
    input  dec_t                   dec,
    input  logic                   secure,
    input  logic [NUM_IRQ-1:0]     en,
    input  logic [NUM_IRQ-1:0]     pend,
    input  logic [NUM_IRQ-1:0]     act,
    input  logic [NUM_IRQ-1:0]     tgt_ns,
    input  logic [NUM_IRQ*8-1:0]   prio,
    output logic [31:0]            rdata,
    output logic                   err
);
    localparam logic [31:0] TYPE_VAL = 32'(NUM_IRQ / 32 - 1);

    logic [31:0] en_w, pend_w, act_w, tgt_w, prio_w;

    always_comb begin
        en_w   = '0;
        pend_w = '0;
        act_w  = '0;
        tgt_w  = '0;
        prio_w = '0;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (6'(i / 32) == dec.idx) begin
                en_w[i % 32]   = en[i]   & (secure | tgt_ns[i]);
                pend_w[i % 32] = pend[i] & (secure | tgt_ns[i]);
                act_w[i % 32]  = act[i]  & (secure | tgt_ns[i]);
                tgt_w[i % 32]  = tgt_ns[i];
            end
            if (6'(i / 4) == dec.idx && (secure || tgt_ns[i]))
                prio_w[8*(i % 4) +: 8] = prio[8*i +: 8];
        end
    end

    always_comb begin
        err = 1'b0;
        case (dec.rg)
            RG_TYPE:                rdata = TYPE_VAL;
            RG_SETEN, RG_CLREN:     rdata = en_w;
            RG_SETPEND, RG_CLRPEND: rdata = pend_w;
            RG_ACTIVE:              rdata = act_w;
            RG_TARGET:              rdata = secure ? tgt_w : '0;
            RG_PRIO:                rdata = prio_w;
            default: begin
                rdata = '0;
                err   = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/sirq_bank.sv
module sirq_bank
    import sirq_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter bit SEC_EXT = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 acc_valid,
    input  logic                 acc_write,
    input  logic                 acc_secure,
    input  logic [11:0]          acc_addr,
    input  logic [31:0]          acc_wdata,
    output logic                 rsp_valid,
    output logic [31:0]          rsp_rdata,
    output logic                 rsp_err,
    input  logic [NUM_IRQ-1:0]   act_set,
    input  logic [NUM_IRQ-1:0]   act_clr,
    output logic [NUM_IRQ-1:0]   irq_enabled,
    output logic [NUM_IRQ-1:0]   irq_pending,
    output logic [NUM_IRQ-1:0]   irq_active,
    output logic [NUM_IRQ-1:0]   irq_target_ns,
    output logic [NUM_IRQ*8-1:0] irq_prio
);
    localparam int N_BM = NUM_IRQ / 32;
    localparam int N_PR = NUM_IRQ / 4;

    dec_t        dec;
    logic        wr_stb;
    logic [31:0] rd_data;
    logic        rd_err;

    assign dec    = decode_addr(acc_addr, N_BM, N_PR, SEC_EXT);
    assign wr_stb = acc_valid && acc_write;

    generate
        for (genvar g = 0; g < NUM_IRQ; g++) begin : g_cell
            sirq_irq_cell #(
                .IRQ_ID  (g),
                .SEC_EXT (SEC_EXT)
            ) u_cell (
                .clk      (clk),
                .rst      (rst),
                .wr_stb   (wr_stb),
                .dec      (dec),
                .wdata    (acc_wdata),
                .secure   (acc_secure),
                .act_set  (act_set[g]),
                .act_clr  (act_clr[g]),
                .en_o     (irq_enabled[g]),
                .pend_o   (irq_pending[g]),
                .act_o    (irq_active[g]),
                .tgt_ns_o (irq_target_ns[g]),
                .prio_o   (irq_prio[8*g +: 8])
            );
        end
    endgenerate

    sirq_rd_mux #(.NUM_IRQ(NUM_IRQ)) u_rd_mux (
        .dec    (dec),
        .secure (acc_secure),
        .en     (irq_enabled),
        .pend   (irq_pending),
        .act    (irq_active),
        .tgt_ns (irq_target_ns),
        .prio   (irq_prio),
        .rdata  (rd_data),
        .err    (rd_err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_valid <= acc_valid;
            rsp_rdata <= (acc_valid && !acc_write) ? rd_data : '0;
            rsp_err   <= acc_valid && rd_err;
        end
    end

endmodule

// File: rtl/sirq_bank_chk.sv
module sirq_bank_chk #(
    parameter int NUM_IRQ = 64,
    parameter bit SEC_EXT = 1'b1
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 acc_valid,
    input logic                 acc_write,
    input logic                 acc_secure,
    input logic [11:0]          acc_addr,
    input logic                 rsp_valid,
    input logic [31:0]          rsp_rdata,
    input logic                 rsp_err,
    input logic [NUM_IRQ-1:0]   act_set,
    input logic [NUM_IRQ-1:0]   act_clr,
    input logic [NUM_IRQ-1:0]   irq_enabled,
    input logic [NUM_IRQ-1:0]   irq_pending,
    input logic [NUM_IRQ-1:0]   irq_active,
    input logic [NUM_IRQ-1:0]   irq_target_ns
);
    assert_type_value_R1: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_write && acc_addr[11:2] == '0)
        |=> (rsp_rdata == 32'(NUM_IRQ / 32 - 1) && !rsp_err));

    assert_active_wr_ignored_R4: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_write && act_set == '0 && act_clr == '0)
        |=> $stable(irq_active));

    assert_ns_target_read_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_write && !acc_secure && acc_addr[11:7] == 5'd7)
        |=> (rsp_rdata == '0));

    assert_ns_target_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_write && !acc_secure) |=> $stable(irq_target_ns));

    assert_ns_enable_guard_R8: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_write && !acc_secure)
        |=> (((irq_enabled ^ $past(irq_enabled)) & ~$past(irq_target_ns)) == '0));

    assert_ns_pending_guard_R8: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_write && !acc_secure)
        |=> (((irq_pending ^ $past(irq_pending)) & ~$past(irq_target_ns)) == '0));

    assert_err_reads_zero_R12: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> (rsp_rdata == '0));

    assert_rsp_follows_R14: assert property (@(posedge clk) disable iff (rst)
        acc_valid |=> rsp_valid);

    assert_rsp_idle_R14: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> !rsp_valid);

    generate
        if (!SEC_EXT) begin : g_noext
            assert_noext_target_R11: assert property (@(posedge clk) disable iff (rst)
                (&irq_target_ns));
        end
    endgenerate

endmodule

bind sirq_bank sirq_bank_chk #(.NUM_IRQ(NUM_IRQ), .SEC_EXT(SEC_EXT)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .acc_valid     (acc_valid),
    .acc_write     (acc_write),
    .acc_secure    (acc_secure),
    .acc_addr      (acc_addr),
    .rsp_valid     (rsp_valid),
    .rsp_rdata     (rsp_rdata),
    .rsp_err       (rsp_err),
    .act_set       (act_set),
    .act_clr       (act_clr),
    .irq_enabled   (irq_enabled),
    .irq_pending   (irq_pending),
    .irq_active    (irq_active),
    .irq_target_ns (irq_target_ns)
);

// File: tb/sirq_bank_tb.sv
`timescale 1ns/1ps
module sirq_bank_tb;
    localparam int NI = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic          acc_valid = 0, acc_write = 0, acc_secure = 0;
    logic [11:0]   acc_addr = '0;
    logic [31:0]   acc_wdata = '0;
    logic          rsp_valid, rsp_err;
    logic [31:0]   rsp_rdata;
    logic [NI-1:0] act_set = '0, act_clr = '0;
    logic [NI-1:0] irq_enabled, irq_pending, irq_active, irq_target_ns;
    logic [NI*8-1:0] irq_prio;

    logic          x_valid = 0, x_write = 0, x_secure = 0;
    logic [11:0]   x_addr = '0;
    logic [31:0]   x_wdata = '0;
    logic          x_rsp_valid, x_rsp_err;
    logic [31:0]   x_rsp_rdata;
    logic [NI-1:0] x_en, x_pend, x_act, x_tgt;
    logic [NI*8-1:0] x_prio;

    sirq_bank #(.NUM_IRQ(NI), .SEC_EXT(1'b1)) u_dut (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_secure(acc_secure), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .act_set(act_set), .act_clr(act_clr), .irq_enabled(irq_enabled),
        .irq_pending(irq_pending), .irq_active(irq_active),
        .irq_target_ns(irq_target_ns), .irq_prio(irq_prio));

    sirq_bank #(.NUM_IRQ(NI), .SEC_EXT(1'b0)) u_dut_noext (
        .clk(clk), .rst(rst), .acc_valid(x_valid), .acc_write(x_write),
        .acc_secure(x_secure), .acc_addr(x_addr), .acc_wdata(x_wdata),
        .rsp_valid(x_rsp_valid), .rsp_rdata(x_rsp_rdata), .rsp_err(x_rsp_err),
        .act_set('0), .act_clr('0), .irq_enabled(x_en),
        .irq_pending(x_pend), .irq_active(x_act),
        .irq_target_ns(x_tgt), .irq_prio(x_prio));

    int checks = 0;
    int errors = 0;

    task automatic check(input int req, input string what,
                         input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL R%0d %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    logic [31:0] rd;
    logic        er, rv;

    task automatic access(input bit nx, input bit we, input bit sec,
                          input logic [11:0] addr, input logic [31:0] wd);
        @(negedge clk);
        if (!nx) begin
            acc_valid = 1; acc_write = we; acc_secure = sec;
            acc_addr = addr; acc_wdata = wd;
        end else begin
            x_valid = 1; x_write = we; x_secure = sec;
            x_addr = addr; x_wdata = wd;
        end
        @(negedge clk);
        acc_valid = 0; x_valid = 0;
        rd = nx ? x_rsp_rdata : rsp_rdata;
        er = nx ? x_rsp_err   : rsp_err;
        rv = nx ? x_rsp_valid : rsp_valid;
    endtask

    typedef struct packed {
        logic        we;
        logic        sec;
        logic [11:0] addr;
        logic [31:0] wd;
        logic [31:0] exp;
        logic        err;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 45;
    localparam vec_t VEC [NV] = '{
        '{1'b0,1'b1,12'h000,32'h0,32'h1,1'b0,8'd1},          // R1 type value
        '{1'b1,1'b0,12'h000,32'hFF,32'h0,1'b0,8'd1},         // R1 write ignored
        '{1'b0,1'b0,12'h000,32'h0,32'h1,1'b0,8'd1},          // R1
        '{1'b0,1'b1,12'h380,32'h0,32'h0,1'b0,8'd10},         // R10 targets secure
        '{1'b1,1'b1,12'h380,32'hF0,32'h0,1'b0,8'd6},         // R6 irqs 4-7 ns
        '{1'b0,1'b1,12'h380,32'h0,32'hF0,1'b0,8'd6},         // R6
        '{1'b0,1'b0,12'h380,32'h0,32'h0,1'b0,8'd7},          // R7 ns read zero
        '{1'b1,1'b0,12'h380,32'hFFFFFFFF,32'h0,1'b0,8'd7},   // R7 ns write
        '{1'b0,1'b1,12'h380,32'h0,32'hF0,1'b0,8'd7},         // R7 unchanged
        '{1'b1,1'b0,12'h100,32'hFF,32'h0,1'b0,8'd8},         // R8 ns set-en
        '{1'b0,1'b1,12'h100,32'h0,32'hF0,1'b0,8'd8},         // R8
        '{1'b1,1'b1,12'h100,32'h0F,32'h0,1'b0,8'd2},         // R2
        '{1'b0,1'b0,12'h180,32'h0,32'hF0,1'b0,8'd8},         // R8 masked read
        '{1'b0,1'b1,12'h180,32'h0,32'hFF,1'b0,8'd2},         // R2 clr word reads
        '{1'b1,1'b0,12'h180,32'hFF,32'h0,1'b0,8'd8},         // R8 ns clr-en
        '{1'b0,1'b1,12'h100,32'h0,32'h0F,1'b0,8'd8},         // R8
        '{1'b1,1'b1,12'h180,32'h01,32'h0,1'b0,8'd2},         // R2 zeros no effect
        '{1'b0,1'b1,12'h100,32'h0,32'h0E,1'b0,8'd2},         // R2
        '{1'b1,1'b1,12'h204,32'h80000001,32'h0,1'b0,8'd3},   // R3 word 1
        '{1'b0,1'b1,12'h204,32'h0,32'h80000001,1'b0,8'd3},   // R3
        '{1'b0,1'b1,12'h284,32'h0,32'h80000001,1'b0,8'd3},   // R3
        '{1'b0,1'b0,12'h204,32'h0,32'h0,1'b0,8'd8},          // R8 secure irqs hidden
        '{1'b1,1'b1,12'h284,32'h1,32'h0,1'b0,8'd3},          // R3 clear irq 32
        '{1'b0,1'b1,12'h204,32'h0,32'h80000000,1'b0,8'd3},   // R3
        '{1'b1,1'b1,12'h300,32'hFFFF,32'h0,1'b0,8'd4},       // R4 write ignored
        '{1'b0,1'b1,12'h300,32'h0,32'h0,1'b0,8'd4},          // R4
        '{1'b1,1'b1,12'h404,32'h44332211,32'h0,1'b0,8'd5},   // R5 irqs 4-7
        '{1'b0,1'b1,12'h404,32'h0,32'h44332211,1'b0,8'd5},   // R5
        '{1'b0,1'b0,12'h404,32'h0,32'h44332211,1'b0,8'd9},   // R9 ns lanes visible
        '{1'b1,1'b1,12'h400,32'h11223344,32'h0,1'b0,8'd5},   // R5
        '{1'b0,1'b0,12'h400,32'h0,32'h0,1'b0,8'd9},          // R9 secure lanes zero
        '{1'b1,1'b0,12'h400,32'hFFFFFFFF,32'h0,1'b0,8'd9},   // R9 ignored
        '{1'b0,1'b1,12'h400,32'h0,32'h11223344,1'b0,8'd9},   // R9
        '{1'b1,1'b1,12'h380,32'hF2,32'h0,1'b0,8'd13},        // R13 irq1 -> ns
        '{1'b0,1'b0,12'h400,32'h0,32'h00003300,1'b0,8'd13},  // R13 lane 1 only
        '{1'b1,1'b0,12'h400,32'hFFFFFFFF,32'h0,1'b0,8'd13},  // R13 write lane 1
        '{1'b0,1'b1,12'h400,32'h0,32'h1122FF44,1'b0,8'd9},   // R9 mixed word
        '{1'b0,1'b1,12'h108,32'h0,32'h0,1'b1,8'd12},         // R12 word past count
        '{1'b0,1'b1,12'h600,32'h0,32'h0,1'b1,8'd12},         // R12 hole
        '{1'b0,1'b1,12'h440,32'h0,32'h0,1'b1,8'd12},         // R12 prio past count
        '{1'b1,1'b1,12'h388,32'hFFFFFFFF,32'h0,1'b1,8'd12},  // R12 write err
        '{1'b0,1'b1,12'h380,32'h0,32'hF2,1'b0,8'd12},        // R12 no change
        '{1'b0,1'b1,12'h384,32'h0,32'h0,1'b0,8'd6},          // R6 word 1
        '{1'b0,1'b1,12'h43C,32'h0,32'h0,1'b0,8'd5},          // R5 last prio word
        '{1'b0,1'b0,12'h100,32'h0,32'h02,1'b0,8'd13}         // R13 ns enable view
    };

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check(10, "reset enables", 64'(irq_enabled), 64'h0);
        check(10, "reset targets", 64'(irq_target_ns), 64'h0);
        check(10, "reset prio zero", 64'(|irq_prio), 64'h0);
        check(14, "no response in reset", 64'(rsp_valid), 64'h0);
        check(11, "noext targets all ns", 64'(x_tgt), {64{1'b1}});
        @(negedge clk); rst = 0;

        foreach (VEC[k]) begin
            access(0, VEC[k].we, VEC[k].sec, VEC[k].addr, VEC[k].wd);
            check(int'(VEC[k].req), $sformatf("vec %0d rdata", k), 64'(rd), 64'(VEC[k].exp));
            check(int'(VEC[k].req), $sformatf("vec %0d err", k), 64'(er), 64'(VEC[k].err));
        end

        // R14 response timing
        access(0, 0, 1, 12'h000, 0);
        check(14, "rsp_valid after access", 64'(rv), 64'h1);
        @(negedge clk);
        check(14, "rsp_valid idle", 64'(rsp_valid), 64'h0);

        // R4 active side-band; irq5 targets ns, irq40 secure
        @(negedge clk); act_set[5] = 1; act_set[40] = 1;
        @(negedge clk); act_set = '0;
        access(0, 0, 1, 12'h300, 0); check(4, "active w0 secure", 64'(rd), 64'h20);
        access(0, 0, 1, 12'h304, 0); check(4, "active w1 secure", 64'(rd), 64'h100);
        access(0, 0, 0, 12'h304, 0); check(8, "active w1 ns masked", 64'(rd), 64'h0);
        access(0, 0, 0, 12'h300, 0); check(8, "active w0 ns", 64'(rd), 64'h20);
        @(negedge clk); act_set[5] = 1; act_clr[5] = 1;
        @(negedge clk); act_set = '0; act_clr = '0;
        check(4, "set wins over clear", 64'(irq_active[5]), 64'h1);
        @(negedge clk); act_clr[5] = 1;
        @(negedge clk); act_clr = '0;
        access(0, 0, 1, 12'h300, 0); check(4, "active cleared", 64'(rd), 64'h0);

        // R11 no extension
        access(1, 0, 0, 12'h380, 0);
        check(11, "noext window rdata", 64'(rd), 64'h0);
        check(11, "noext window err", 64'(er), 64'h1);
        access(1, 1, 1, 12'h380, 32'h0);
        check(11, "noext window write err", 64'(er), 64'h1);
        check(11, "noext targets stay 1", 64'(x_tgt), {64{1'b1}});
        access(1, 1, 0, 12'h100, 32'h5);
        access(1, 0, 0, 12'h100, 0);
        check(11, "noext ns enables", 64'(rd), 64'h5);

        // R10 reset mid-run
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        check(10, "re-reset enables", 64'(irq_enabled), 64'h0);
        check(10, "re-reset pending", 64'(irq_pending), 64'h0);
        check(10, "re-reset targets", 64'(irq_target_ns), 64'h0);
        check(10, "re-reset prio", 64'(|irq_prio), 64'h0);
        access(0, 0, 1, 12'h380, 0);
        check(10, "re-reset target read", 64'(rd), 64'h0);

        finish_run();
    end
endmodule